// File: doc/BRIEF.md
# Interrupt Status and Exception PC Unit

This block keeps the privileged control state a pipelined processor needs to enter and leave exception handlers. It holds the saved program counter of the interrupted instruction, a cause register, a status register with the current interrupt-enable and kernel-mode bits plus a one-level saved copy of both, and a per-line interrupt mask register. External interrupt request lines are filtered by the mask and by the global enable bit. The block reports whether an interrupt is pending and which line wins by fixed priority.

The pipeline raises a commit strobe with the faulting PC and a cause code when an exception or interrupt is taken at its commit point. The unit then saves the PC and cause, pushes the mode and enable bits into the saved pair, disables interrupts and enters kernel mode. A return strobe pops the saved pair back. Handler code reads the registers through a selected read port, which lets it copy the saved PC into a general register before re-enabling interrupts for nesting. It changes the registers with bit-masked writes that take effect only in kernel mode.

Top module: `isu_top`

## Requirements
- R1: Among the request lines whose mask bit is 1, the lowest-numbered asserted line wins; `irq_code` is its index (0 when no line qualifies).
- R2: `irq_pending` is 1 exactly when the enable bit is 1 and at least one asserted line has its mask bit set to 1.
- R3: One cycle after `exc_commit`, the saved PC equals `exc_pc` and the cause code equals `exc_code`.
- R4: On `exc_commit`, the previous-enable and previous-kernel bits take the old enable and kernel bits, enable becomes 0 and kernel becomes 1.
- R5: On `rfe`, the enable and kernel bits take the previous-enable and previous-kernel bits; the previous pair is left unchanged.
- R6: `csr_rdata` shows the register chosen by `csr_sel`: 0 saved PC, 1 cause (code in bits 4:0, raw request lines from bit 8 upward), 2 status (bit 0 enable, bit 1 kernel, bit 2 previous enable, bit 3 previous kernel), 3 mask.
- R7: A write in kernel mode changes only the bits of the selected register where `csr_wmask` is 1, which take the value of `csr_wdata`.
- R8: A write while in user mode (kernel bit 0) changes no register.
- R9: When strobes coincide, `exc_commit` takes precedence over `rfe`, and both take precedence over a write.
- R10: Reset, synchronous and active high, sets kernel 1, enable 0, previous pair 0, and the saved PC, cause and mask to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NIRQ | External interrupt request lines |
| exc_commit | input | 1 | Exception or interrupt taken at commit |
| exc_pc | input | XLEN | PC of the interrupted instruction |
| exc_code | input | CODE_W | Cause code of the event |
| rfe | input | 1 | Return-from-exception strobe |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select for read and write |
| csr_wdata | input | XLEN | Write data |
| csr_wmask | input | XLEN | Per-bit write enable |
| csr_rdata | output | XLEN | Read data of the selected register |
| irq_pending | output | 1 | An enabled, unmasked interrupt is requesting |
| irq_code | output | IDX_W | Index of the winning request line |
| int_enable | output | 1 | Current global interrupt enable |
| kernel_mode | output | 1 | Current mode, 1 for kernel |
| epc_value | output | XLEN | Saved PC |

## Verification
On every cycle the assertions check that a reported winner is asserted and unmasked with no lower-numbered contender, that nothing is pending while interrupts are disabled, that entry saves the PC and lands in kernel mode with interrupts off, that return restores the saved pair, and that user-mode writes leave the saved PC and status untouched. Only the bench's scenarios show the full read-port layout, the bit-masked write results, nesting of entry over an earlier return, and the precedence between coinciding strobes, by comparing every cycle against a behavioural model.

// File: rtl/isu_pkg.sv
package isu_pkg;

    typedef enum logic [1:0] {
        SEL_EPC    = 2'd0,
        SEL_CAUSE  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_MASK   = 2'd3
    } csr_sel_e;

    // bit 0 enable, bit 1 kernel, bit 2 prev enable, bit 3 prev kernel
    typedef struct packed {
        logic prev_kernel;
        logic prev_ie;
        logic kernel;
        logic ie;
    } status_t;

    localparam status_t STATUS_RESET = '{prev_kernel: 1'b0, prev_ie: 1'b0,
                                         kernel: 1'b1, ie: 1'b0};

    function automatic status_t status_enter(status_t s);
        status_t n;
        n.prev_kernel = s.kernel;
        n.prev_ie     = s.ie;
        n.kernel      = 1'b1;
        n.ie          = 1'b0;
        return n;
    endfunction

    function automatic status_t status_return(status_t s);
        status_t n;
        n             = s;
        n.kernel      = s.prev_kernel;
        n.ie          = s.prev_ie;
        return n;
    endfunction

    function automatic status_t status_merge(status_t s, logic [3:0] d, logic [3:0] m);
        return status_t'((4'(s) & ~m) | (d & m));
    endfunction

endpackage

// File: rtl/isu_irq_prio.sv
module isu_irq_prio #(
    parameter int NIRQ  = 8,
    parameter int IDX_W = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIRQ-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    // lower[i] is set when some line below i requests
    logic [NIRQ-1:0] lower;

    assign lower[0] = 1'b0;
    for (genvar g = 1; g < NIRQ; g++) begin : g_chain
        assign lower[g] = lower[g-1] | req[g-1];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NIRQ; i++) begin
            if (req[i] && !lower[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;

    AST_WINNER_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        any |-> req[idx]); // R1
    AST_NO_LOWER_CONTENDER: assert property (@(posedge clk) disable iff (rst)
        any |-> ((req & ((NIRQ'(1) << idx) - NIRQ'(1))) == '0)); // R1

endmodule

// File: rtl/isu_state.sv
module isu_state
    import isu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NIRQ   = 8,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_commit,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              rfe,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [XLEN-1:0]   csr_wmask,
    output logic [XLEN-1:0]   epc_q,
    output logic [CODE_W-1:0] cause_q,
    output status_t           status_q,
    output logic [NIRQ-1:0]   mask_q
);
    logic     wr_ok;
    csr_sel_e sel;

    assign sel   = csr_sel_e'(csr_sel);
    assign wr_ok = csr_we && status_q.kernel && !exc_commit && !rfe;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc_q    <= '0;
            cause_q  <= '0;
            status_q <= STATUS_RESET;
            mask_q   <= '0;
        end else if (exc_commit) begin
            epc_q    <= exc_pc;
            cause_q  <= exc_code;
            status_q <= status_enter(status_q);
        end else if (rfe) begin
            status_q <= status_return(status_q);
        end else if (wr_ok) begin
            case (sel)
                SEL_EPC:    epc_q <= (epc_q & ~csr_wmask) | (csr_wdata & csr_wmask);
                SEL_CAUSE:  cause_q <= (cause_q & ~csr_wmask[CODE_W-1:0])
                                     | (csr_wdata[CODE_W-1:0] & csr_wmask[CODE_W-1:0]);
                SEL_STATUS: status_q <= status_merge(status_q, csr_wdata[3:0], csr_wmask[3:0]);
                SEL_MASK:   mask_q <= (mask_q & ~csr_wmask[NIRQ-1:0])
                                    | (csr_wdata[NIRQ-1:0] & csr_wmask[NIRQ-1:0]);
                default: ;
            endcase
        end
    end

    AST_ENTRY_SAVES_PC: assert property (@(posedge clk) disable iff (rst)
        exc_commit |=> (epc_q == $past(exc_pc)) && (cause_q == $past(exc_code))); // R3
    AST_ENTRY_KERNEL: assert property (@(posedge clk) disable iff (rst)
        exc_commit |=> status_q.kernel && !status_q.ie
                       && (status_q.prev_ie == $past(status_q.ie))); // R4
    AST_RFE_POPS: assert property (@(posedge clk) disable iff (rst)
        (rfe && !exc_commit) |=> (status_q.ie == $past(status_q.prev_ie))
                                 && (status_q.kernel == $past(status_q.prev_kernel))); // R5
    AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (csr_we && !status_q.kernel && !exc_commit && !rfe)
            |=> $stable(epc_q) && $stable(status_q) && $stable(mask_q)); // R8

endmodule

// File: rtl/isu_top.sv
module isu_top
    import isu_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NIRQ      = 8,
    parameter int CODE_W    = 5,
    parameter int PEND_LSB  = 8,
    parameter int IDX_W     = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NIRQ-1:0]   irq_lines,
    input  logic              exc_commit,
    input  logic [XLEN-1:0]   exc_pc,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              rfe,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic [XLEN-1:0]   csr_wmask,
    output logic [XLEN-1:0]   csr_rdata,
    output logic              irq_pending,
    output logic [IDX_W-1:0]  irq_code,
    output logic              int_enable,
    output logic              kernel_mode,
    output logic [XLEN-1:0]   epc_value
);
    logic [XLEN-1:0]   epc_q;
    logic [CODE_W-1:0] cause_q;
    status_t           status_q;
    logic [NIRQ-1:0]   mask_q;
    logic [NIRQ-1:0]   live_req;
    logic              any_req;

    isu_state #(.XLEN(XLEN), .NIRQ(NIRQ), .CODE_W(CODE_W)) u_state (
        .clk(clk), .rst(rst),
        .exc_commit(exc_commit), .exc_pc(exc_pc), .exc_code(exc_code),
        .rfe(rfe), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_wmask(csr_wmask),
        .epc_q(epc_q), .cause_q(cause_q), .status_q(status_q), .mask_q(mask_q)
    );

    assign live_req = irq_lines & mask_q;

    isu_irq_prio #(.NIRQ(NIRQ), .IDX_W(IDX_W)) u_prio (
        .clk(clk), .rst(rst), .req(live_req), .any(any_req), .idx(irq_code)
    );

    assign irq_pending = any_req && status_q.ie;
    assign int_enable  = status_q.ie;
    assign kernel_mode = status_q.kernel;
    assign epc_value   = epc_q;

    always_comb begin
        csr_rdata = '0;
        case (csr_sel_e'(csr_sel))
            SEL_EPC:    csr_rdata = epc_q;
            SEL_CAUSE: begin
                csr_rdata[CODE_W-1:0]       = cause_q;
                csr_rdata[PEND_LSB +: NIRQ] = irq_lines;
            end
            SEL_STATUS: csr_rdata[3:0]      = 4'(status_q);
            SEL_MASK:   csr_rdata[NIRQ-1:0] = mask_q;
            default: ;
        endcase
    end

    AST_NO_PEND_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !int_enable |-> !irq_pending); // R2
    AST_PEND_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        irq_pending |-> (irq_lines[irq_code] && mask_q[irq_code])); // R2

endmodule

// File: tb/isu_top_bench.sv
module isu_top_bench;
    localparam int XLEN = 32, NIRQ = 8, CODE_W = 5, IDX_W = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NIRQ-1:0] irq_lines = '0;
    logic exc_commit = 1'b0;
    logic [XLEN-1:0] exc_pc = '0;
    logic [CODE_W-1:0] exc_code = '0;
    logic rfe = 1'b0, csr_we = 1'b0;
    logic [1:0] csr_sel = '0;
    logic [XLEN-1:0] csr_wdata = '0, csr_wmask = '0;
    logic [XLEN-1:0] csr_rdata, epc_value;
    logic irq_pending, int_enable, kernel_mode;
    logic [IDX_W-1:0] irq_code;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    // behavioural model state
    logic [XLEN-1:0] m_epc;
    logic [CODE_W-1:0] m_cause;
    logic m_ie, m_k, m_pie, m_pk;
    logic [NIRQ-1:0] m_mask;

    always #5 clk = ~clk;

    isu_top u_isu_top (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .exc_commit(exc_commit),
        .exc_pc(exc_pc), .exc_code(exc_code), .rfe(rfe), .csr_we(csr_we),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata), .csr_wmask(csr_wmask),
        .csr_rdata(csr_rdata), .irq_pending(irq_pending), .irq_code(irq_code),
        .int_enable(int_enable), .kernel_mode(kernel_mode), .epc_value(epc_value)
    );

    task automatic check(string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_epc = '0; m_cause = '0; m_ie = 0; m_k = 1; m_pie = 0; m_pk = 0; m_mask = '0;
    endtask

    // compare outputs for current model state and applied inputs
    task automatic compare();
        logic [XLEN-1:0] rd;
        logic [NIRQ-1:0] q;
        logic [IDX_W-1:0] win;
        q = irq_lines & m_mask;
        win = '0;
        for (int i = NIRQ - 1; i >= 0; i--) if (q[i]) win = IDX_W'(i);
        rd = '0;
        case (csr_sel)
            2'd0: rd = m_epc;
            2'd1: begin rd[4:0] = m_cause; rd[15:8] = irq_lines; end
            2'd2: rd[3:0] = {m_pk, m_pie, m_k, m_ie};
            default: rd[7:0] = m_mask;
        endcase
        check("R6 read port", csr_rdata, rd);
        check("R2 pending", 32'(irq_pending), 32'(m_ie && (q != 0)));
        check("R1 winner", 32'(irq_code), 32'(win));
        check("R4 R5 R10 enable/mode", {30'd0, kernel_mode, int_enable}, {30'd0, m_k, m_ie});
        check("R3 saved PC", epc_value, m_epc);
    endtask

    task automatic model_step();
        if (exc_commit) begin  // R9: entry first
            m_epc = exc_pc; m_cause = exc_code;
            m_pie = m_ie; m_pk = m_k; m_ie = 0; m_k = 1;
        end else if (rfe) begin
            m_ie = m_pie; m_k = m_pk;
        end else if (csr_we && m_k) begin  // R7, user writes dropped R8
            case (csr_sel)
                2'd0: m_epc = (m_epc & ~csr_wmask) | (csr_wdata & csr_wmask);
                2'd1: m_cause = (m_cause & ~csr_wmask[4:0]) | (csr_wdata[4:0] & csr_wmask[4:0]);
                2'd2: {m_pk, m_pie, m_k, m_ie} = ({m_pk, m_pie, m_k, m_ie} & ~csr_wmask[3:0])
                                                | (csr_wdata[3:0] & csr_wmask[3:0]);
                default: m_mask = (m_mask & ~csr_wmask[7:0]) | (csr_wdata[7:0] & csr_wmask[7:0]);
            endcase
        end
    endtask

    task automatic step(logic [7:0] ln, logic ex, logic [31:0] pc, logic [4:0] code,
                        logic rt, logic we, logic [1:0] sel, logic [31:0] wd, logic [31:0] wm);
        @(negedge clk);
        irq_lines = ln; exc_commit = ex; exc_pc = pc; exc_code = code;
        rfe = rt; csr_we = we; csr_sel = sel; csr_wdata = wd; csr_wmask = wm;
        #1 compare();
        model_step();
    endtask

    task automatic idle(logic [7:0] ln, logic [1:0] sel);
        step(ln, 0, 0, 0, 0, 0, sel, 0, 0);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state through every read selection
        for (int s = 0; s < 4; s++) idle(8'h00, 2'(s));
        // R2 mask all zero: nothing pending even with lines up
        idle(8'hFF, 2'd1);
        // R7 masked writes in kernel mode
        step(0, 0, 0, 0, 0, 1, 2'd3, 32'h0000_00FF, 32'h0000_003C);
        idle(0, 2'd3);
        step(0, 0, 0, 0, 0, 1, 2'd3, 32'h0000_00FF, 32'h0000_00FF);
        step(0, 0, 0, 0, 0, 1, 2'd0, 32'hDEAD_BEEF, 32'hFFFF_0000);
        idle(0, 2'd0);
        step(0, 0, 0, 0, 0, 1, 2'd1, 32'h0000_0015, 32'h0000_000F);
        idle(8'hA5, 2'd1);
        // R2 lines up but enable still off
        idle(8'h30, 2'd2);
        // enable interrupts, leave kernel
        step(0, 0, 0, 0, 0, 1, 2'd2, 32'h1, 32'h1);
        // R1 priority patterns
        idle(8'h80, 2'd2); idle(8'h30, 2'd2); idle(8'h0A, 2'd2); idle(8'hFF, 2'd2);
        // mask off line 1: line 3 wins R1
        step(8'h0A, 0, 0, 0, 0, 1, 2'd3, 32'h0, 32'h2);
        idle(8'h0A, 2'd3);
        // set prev pair to user + enabled, then return R5
        step(0, 0, 0, 0, 0, 1, 2'd2, 32'h4, 32'hC);
        step(0, 0, 0, 0, 1, 0, 2'd2, 0, 0);
        idle(8'h08, 2'd2);
        // R8 user-mode writes ignored (observed via read port)
        step(0, 0, 0, 0, 0, 1, 2'd0, 32'h1234_5678, 32'hFFFF_FFFF);
        idle(0, 2'd0);
        step(0, 0, 0, 0, 0, 1, 2'd2, 32'h2, 32'hF);
        idle(0, 2'd2);
        step(0, 0, 0, 0, 0, 1, 2'd3, 32'h0, 32'hFF);
        idle(8'h40, 2'd3);
        // R3 R4 entry from user mode with interrupt pending
        step(8'h40, 1, 32'h0000_0104, 5'd0, 0, 0, 2'd2, 0, 0);
        idle(8'h40, 2'd1); idle(8'h40, 2'd0); idle(8'h40, 2'd2);
        // re-enable for nesting, nested entry R4
        step(0, 0, 0, 0, 0, 1, 2'd2, 32'h1, 32'h1);
        step(8'h01, 1, 32'h0000_0200, 5'd12, 0, 0, 2'd2, 0, 0);
        idle(8'h01, 2'd2);
        // R9 entry with rfe and write in same cycle
        step(0, 1, 32'h0000_0300, 5'd8, 1, 1, 2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle(0, 2'd0);
        // R9 rfe beats write
        step(0, 0, 0, 0, 1, 1, 2'd2, 32'h0, 32'hF);
        idle(0, 2'd2);
        step(0, 0, 0, 0, 1, 0, 2'd2, 0, 0);
        idle(8'hFF, 2'd1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule